// File: doc/BRIEF.md
# Windowed Register File with Overlapping Parameter Registers

This block is the integer register file of a RISC-style core that keeps procedure frames in hardware. It holds 138 physical registers: a set of 10 globals that every procedure sees, plus 8 window blocks of 16 registers each, used in a circle. A procedure always addresses 32 logical registers through a 5-bit number. The core decodes that number into one of four regions: globals, outgoing parameters to a callee, private locals and incoming parameters from the caller.

A current-window pointer selects which blocks back the banked regions. A call strobe moves the pointer forward by one window and a return strobe moves it back. The caller's outgoing registers are the same physical registers as the callee's incoming registers, so arguments and results pass between procedures with no copying. The block counts how many caller frames are still held in the file. A call that would run into the oldest resident frame raises an overflow flag, and a return with no resident caller raises an underflow flag. Trap software saves or restores one frame and then retries the strobe. The block itself never copies to memory. It only tracks the frame counts that such software implies.

There are two combinational read ports and one write port that writes on the clock edge. A write forwards to a read of the same register in the same cycle.

Top module: `rwin_file`

## Requirements
- R1: After synchronous reset every one of the 32 logical registers reads 0, the window pointer is window 0, and no caller frames and no saved frames are counted.
- R2: Logical registers 0..9 are globals and map to the same physical registers in every window.
- R3: Logical registers 10..15 (outgoing) of window w are the same physical registers as logical registers 26..31 (incoming) of window (w+1) mod 8, in the same order.
- R4: Logical registers 16..25 are locals private to their window. A write there is never visible from any other window.
- R5: A call accepted while fewer than 6 caller frames are resident advances the window pointer by one modulo 8, wrapping from window 7 to window 0. It also increments the resident frame count.
- R6: A return accepted while at least one caller frame is resident moves the window pointer back by one modulo 8 and decrements the resident frame count.
- R7: A call while 6 caller frames are resident raises the overflow output in that same cycle and leaves the pointer in place. The oldest resident frame is then counted as saved, so a retried call is accepted.
- R8: A return with no resident caller frame raises the underflow output in that same cycle and leaves the pointer in place. If any frame is counted as saved, one is counted back as resident, so a retried return is accepted. With nothing saved, the return has no other effect.
- R9: Reads are combinational from the current window. A write lands on the clock edge. A write and a read of the same register in the same cycle return the write data on the read port.
- R10: Call and return asserted together have no effect: the pointer and counts do not change and neither flag rises.
- R11: A write in the same cycle as a call or a return uses the window that was current before the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| call_i | input | 1 | Procedure call strobe |
| ret_i | input | 1 | Procedure return strobe |
| rd_a_addr_i | input | 5 | Logical register number for read port A |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_addr_i | input | 5 | Logical register number for read port B |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Logical register number to write |
| wr_data_i | input | 32 | Write data |
| ovf_o | output | 1 | Window overflow, valid in the cycle of the call strobe |
| unf_o | output | 1 | Window underflow, valid in the cycle of the return strobe |

## Verification
A pointer that moves one window too far or not at all shows up on the very next read after the strobe. The banked registers then return another window's data, while the globals still look correct. A wrong resident-frame count stays hidden until the frame depth reaches its limit. It then appears as an overflow or underflow flag one call early or one call late. A translation that misplaces the overlap shows up after a single call: the callee's incoming registers disagree with what the caller wrote to its outgoing ones. The sweep therefore writes every register of every window and reads all 32 back after every strobe, carrying the pointer across the wrap point from window 7 to window 0.

// File: rtl/rwin_pkg.sv
package rwin_pkg;

  typedef enum logic [1:0] {
    RG_GLOBAL = 2'd0,
    RG_OUT    = 2'd1,
    RG_LOCAL  = 2'd2,
    RG_IN     = 2'd3
  } region_e;

  // Region of a logical register: globals, outgoing, locals, incoming.
  function automatic region_e region_of(int unsigned lr, int unsigned ng,
                                        int unsigned nov, int unsigned nloc);
    if (lr < ng)                   return RG_GLOBAL;
    else if (lr < ng + nov)        return RG_OUT;
    else if (lr < ng + nov + nloc) return RG_LOCAL;
    else                           return RG_IN;
  endfunction

  // Step a window index forward or back around the circle of n windows.
  function automatic int unsigned wrap_step(int unsigned w, bit up, int unsigned n);
    return up ? (w + 1) % n : (w + n - 1) % n;
  endfunction

  // Physical index of logical register lr seen from window w.
  // A window block holds its incoming registers first, then its locals.
  function automatic int unsigned phys_index(int unsigned lr, int unsigned w,
                                             int unsigned nwin, int unsigned ng,
                                             int unsigned nov, int unsigned nloc);
    int unsigned stride;
    stride = nov + nloc;
    case (region_of(lr, ng, nov, nloc))
      RG_GLOBAL: return lr;
      RG_IN:     return ng + w * stride + (lr - (ng + nov + nloc));
      RG_LOCAL:  return ng + w * stride + nov + (lr - (ng + nov));
      default:   return ng + wrap_step(w, 1'b1, nwin) * stride + (lr - ng);
    endcase
  endfunction

endpackage

// File: rtl/rwin_xlate.sv
module rwin_xlate
  import rwin_pkg::*;
#(
  parameter int NWIN  = 8,
  parameter int NGLOB = 10,
  parameter int NOVL  = 6,
  parameter int NLOC  = 10,
  parameter int LRW   = 5,
  parameter int CW    = 3,
  parameter int PW    = 8
) (
  input  logic [LRW-1:0] lreg_i,
  input  logic [CW-1:0]  win_i,
  output logic [PW-1:0]  phys_o
);

  always_comb begin
    phys_o = PW'(phys_index(int'(lreg_i), int'(win_i), NWIN, NGLOB, NOVL, NLOC));
  end

endmodule

// File: rtl/rwin_ptr.sv
module rwin_ptr
  import rwin_pkg::*;
#(
  parameter int NWIN  = 8,
  parameter int CW    = 3,
  parameter int DEPW  = 3,
  parameter int SPW   = 8
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          call_i,
  input  logic          ret_i,
  output logic [CW-1:0] cwp_o,
  output logic          ovf_o,
  output logic          unf_o
);

  localparam int MAXD = NWIN - 2;

  logic [DEPW-1:0] depth_q;
  logic [SPW-1:0]  saved_q;
  logic            call_only, ret_only;
  logic            call_ok, ret_ok, refill;
  logic            at_max, at_zero, saved_full;

  assign call_only  = call_i & ~ret_i;
  assign ret_only   = ret_i & ~call_i;
  assign at_max     = (depth_q == DEPW'(MAXD));
  assign at_zero    = (depth_q == '0);
  assign saved_full = &saved_q;

  // Named internal events for the assertions.
  assign call_ok = call_only & ~at_max;
  assign ovf_o   = call_only & at_max;
  assign ret_ok  = ret_only & ~at_zero;
  assign unf_o   = ret_only & at_zero;
  assign refill  = unf_o & (saved_q != '0);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cwp_o   <= '0;
      depth_q <= '0;
      saved_q <= '0;
    end else if (call_ok) begin
      cwp_o   <= CW'(wrap_step(int'(cwp_o), 1'b1, NWIN));
      depth_q <= depth_q + 1'b1;
    end else if (ovf_o) begin
      depth_q <= depth_q - 1'b1;
      if (!saved_full) saved_q <= saved_q + 1'b1;
    end else if (ret_ok) begin
      cwp_o   <= CW'(wrap_step(int'(cwp_o), 1'b0, NWIN));
      depth_q <= depth_q - 1'b1;
    end else if (refill) begin
      depth_q <= depth_q + 1'b1;
      saved_q <= saved_q - 1'b1;
    end
  end

  a_r5_call_advances: assert property (@(posedge clk_i) disable iff (rst_i)
    call_ok |=> cwp_o == CW'(wrap_step(int'($past(cwp_o)), 1'b1, NWIN)));
  a_r6_return_retreats: assert property (@(posedge clk_i) disable iff (rst_i)
    ret_ok |=> cwp_o == CW'(wrap_step(int'($past(cwp_o)), 1'b0, NWIN)));
  a_r7_overflow_holds: assert property (@(posedge clk_i) disable iff (rst_i)
    ovf_o |=> $stable(cwp_o) && !ovf_o);
  a_r8_underflow_holds: assert property (@(posedge clk_i) disable iff (rst_i)
    unf_o |=> $stable(cwp_o));
  a_r7_depth_bound: assert property (@(posedge clk_i) disable iff (rst_i)
    depth_q <= DEPW'(MAXD));
  a_r10_both_ignored: assert property (@(posedge clk_i) disable iff (rst_i)
    (call_i && ret_i) |-> !ovf_o && !unf_o ##1 $stable(cwp_o));

endmodule

// File: rtl/rwin_store.sv
module rwin_store #(
  parameter int NPHYS = 138,
  parameter int PW    = 8,
  parameter int DW    = 32,
  parameter int NRD   = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic [NRD-1:0][PW-1:0] rphys_i,
  output logic [NRD-1:0][DW-1:0] rdata_o,
  input  logic                 we_i,
  input  logic [PW-1:0]        wphys_i,
  input  logic [DW-1:0]        wdata_i
);

  logic [DW-1:0] mem_q [NPHYS];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int i = 0; i < NPHYS; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[wphys_i] <= wdata_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic fwd_hit;
    assign fwd_hit    = we_i && (wphys_i == rphys_i[p]);
    assign rdata_o[p] = fwd_hit ? wdata_i : mem_q[rphys_i[p]];

    a_r9_forward_match: assert property (@(posedge clk_i) disable iff (rst_i)
      fwd_hit |-> rdata_o[p] == wdata_i);
  end

  a_r9_write_lands: assert property (@(posedge clk_i) disable iff (rst_i)
    we_i |=> mem_q[$past(wphys_i)] == $past(wdata_i));
  a_r2_index_range: assert property (@(posedge clk_i) disable iff (rst_i)
    we_i |-> int'(wphys_i) < NPHYS);

endmodule

// File: rtl/rwin_file.sv
module rwin_file
  import rwin_pkg::*;
#(
  parameter int NWIN  = 8,
  parameter int NGLOB = 10,
  parameter int NOVL  = 6,
  parameter int NLOC  = 10,
  parameter int DW    = 32,
  parameter int SPW   = 8,
  localparam int NLOG  = NGLOB + 2 * NOVL + NLOC,
  localparam int LRW   = $clog2(NLOG)
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic           call_i,
  input  logic           ret_i,
  input  logic [LRW-1:0] rd_a_addr_i,
  output logic [DW-1:0]  rd_a_data_o,
  input  logic [LRW-1:0] rd_b_addr_i,
  output logic [DW-1:0]  rd_b_data_o,
  input  logic           wr_en_i,
  input  logic [LRW-1:0] wr_addr_i,
  input  logic [DW-1:0]  wr_data_i,
  output logic           ovf_o,
  output logic           unf_o
);

  localparam int NPHYS = NGLOB + NWIN * (NOVL + NLOC);
  localparam int PW    = $clog2(NPHYS);
  localparam int CW    = $clog2(NWIN);
  localparam int DEPW  = $clog2(NWIN);
  localparam int NPORT = 3;  // two reads, one write

  logic [CW-1:0]               cwp;
  logic [NPORT-1:0][LRW-1:0]   lreg;
  logic [NPORT-1:0][PW-1:0]    phys;
  logic [1:0][PW-1:0]          rphys;
  logic [1:0][DW-1:0]          rdata;

  assign lreg[0] = rd_a_addr_i;
  assign lreg[1] = rd_b_addr_i;
  assign lreg[2] = wr_addr_i;

  rwin_ptr #(
    .NWIN (NWIN),
    .CW   (CW),
    .DEPW (DEPW),
    .SPW  (SPW)
  ) u_ptr (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .call_i (call_i),
    .ret_i  (ret_i),
    .cwp_o  (cwp),
    .ovf_o  (ovf_o),
    .unf_o  (unf_o)
  );

  for (genvar k = 0; k < NPORT; k++) begin : g_xl
    rwin_xlate #(
      .NWIN  (NWIN),
      .NGLOB (NGLOB),
      .NOVL  (NOVL),
      .NLOC  (NLOC),
      .LRW   (LRW),
      .CW    (CW),
      .PW    (PW)
    ) u_xl (
      .lreg_i (lreg[k]),
      .win_i  (cwp),
      .phys_o (phys[k])
    );
  end

  assign rphys[0] = phys[0];
  assign rphys[1] = phys[1];

  rwin_store #(
    .NPHYS (NPHYS),
    .PW    (PW),
    .DW    (DW),
    .NRD   (2)
  ) u_store (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .rphys_i (rphys),
    .rdata_o (rdata),
    .we_i    (wr_en_i),
    .wphys_i (phys[2]),
    .wdata_i (wr_data_i)
  );

  assign rd_a_data_o = rdata[0];
  assign rd_b_data_o = rdata[1];

  a_r7_r8_flags_exclusive: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0({ovf_o, unf_o}));
  a_r3_overlap_shared: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_a_addr_i == LRW'(NGLOB) && call_i && !ret_i && !ovf_o)
      |=> (rd_a_addr_i == LRW'(NLOG - NOVL)) -> (rd_a_data_o == $past(rd_a_data_o))
          || $past(wr_en_i));

endmodule

// File: tb/rwin_file_bench.sv
module rwin_file_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NW = 8;
  localparam int LIMIT = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        call = 1'b0, ret = 1'b0;
  logic [4:0]  ra = '0, rb = '0, wa = '0;
  logic [31:0] da, db, wd = '0;
  logic        we = 1'b0;
  logic        ovf, unf;

  int checks = 0;
  int failures = 0;
  int seq = 0;

  logic [31:0] mdl [138];
  int bcwp = 0, bdepth = 0, bspill = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rwin_file u_rwin_file (
    .clk_i       (clk),
    .rst_i       (rst),
    .call_i      (call),
    .ret_i       (ret),
    .rd_a_addr_i (ra),
    .rd_a_data_o (da),
    .rd_b_addr_i (rb),
    .rd_b_data_o (db),
    .wr_en_i     (we),
    .wr_addr_i   (wa),
    .wr_data_i   (wd),
    .ovf_o       (ovf),
    .unf_o       (unf)
  );

  // Bench-side map: owner block of a banked register, then its offset.
  function automatic int bphys(int r, int w);
    int owner;
    int off;
    if (r < 10) return r;
    owner = (r < 16) ? ((w + 1) % NW) : w;
    off   = (r >= 26) ? (r - 26) : (r - 10);
    return 10 + owner * 16 + off;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    for (int r = 0; r < 32; r += 2) begin
      @(negedge clk);
      ra = 5'(r);
      rb = 5'(r + 1);
      #1;
      check(tag, $sformatf("win%0d reg%0d", bcwp, r), da, mdl[bphys(r, bcwp)]);
      check(tag, $sformatf("win%0d reg%0d", bcwp, r + 1), db, mdl[bphys(r + 1, bcwp)]);
    end
  endtask

  task automatic chk_one(string tag, int r);
    @(negedge clk);
    ra = 5'(r);
    #1;
    check(tag, $sformatf("win%0d reg%0d", bcwp, r), da, mdl[bphys(r, bcwp)]);
  endtask

  function automatic logic [31:0] next_data();
    seq++;
    return 32'hA500_0000 ^ (32'(seq) * 32'h9E37_79B1);
  endfunction

  // One cycle with optional strobes and write; flags checked before the edge.
  task automatic strobe(bit c, bit r, bit w, int a, logic [31:0] d, string tag);
    bit eo, eu;
    @(negedge clk);
    call = c; ret = r; we = w; wa = 5'(a); wd = d;
    eo = c && !r && (bdepth == LIMIT);
    eu = r && !c && (bdepth == 0);
    #1;
    check(tag, "overflow flag", 32'(ovf), 32'(eo));
    check(tag, "underflow flag", 32'(unf), 32'(eu));
    @(posedge clk);
    #1;
    call = 1'b0; ret = 1'b0; we = 1'b0;
    if (w) mdl[bphys(a, bcwp)] = d;
    if (c && !r) begin
      if (bdepth == LIMIT) begin bdepth--; bspill++; end
      else begin bcwp = (bcwp + 1) % NW; bdepth++; end
    end
    if (r && !c) begin
      if (bdepth == 0) begin
        if (bspill > 0) begin bdepth = 1; bspill--; end
      end else begin
        bcwp = (bcwp + NW - 1) % NW; bdepth--;
      end
    end
  endtask

  task automatic fill_window();
    for (int r = 0; r < 32; r++) strobe(1'b0, 1'b0, 1'b1, r, next_data(), "R9");
  endtask

  initial begin
    for (int i = 0; i < 138; i++) mdl[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    chk_all("R1");

    fill_window();
    chk_all("R9");
    strobe(1'b1, 1'b0, 1'b0, 0, '0, "R5");
    chk_one("R3", 26);
    chk_one("R3", 31);
    chk_one("R4", 16);
    chk_one("R2", 4);
    fill_window();
    for (int i = 0; i < LIMIT - 1; i++) begin
      strobe(1'b1, 1'b0, 1'b0, 0, '0, "R5");
      chk_all("R5");
      fill_window();
    end

    // Overflow at full depth, then retried calls wrap 6 -> 7 -> 0.
    strobe(1'b1, 1'b0, 1'b0, 0, '0, "R7");
    chk_all("R7");
    strobe(1'b1, 1'b0, 1'b0, 0, '0, "R7");
    chk_all("R7");
    fill_window();
    strobe(1'b1, 1'b0, 1'b0, 0, '0, "R7");
    strobe(1'b1, 1'b0, 1'b0, 0, '0, "R5");
    chk_all("R5");
    fill_window();

    // Same-cycle forwarding on both ports.
    @(negedge clk);
    we = 1'b1; wa = 5'd17; wd = 32'hDEAD_BEEF; ra = 5'd17; rb = 5'd17;
    #1;
    check("R9", "forward port A", da, 32'hDEAD_BEEF);
    check("R9", "forward port B", db, 32'hDEAD_BEEF);
    @(posedge clk);
    #1 we = 1'b0;
    mdl[bphys(17, bcwp)] = 32'hDEAD_BEEF;

    // Call and return together: nothing moves.
    strobe(1'b1, 1'b1, 1'b0, 0, '0, "R10");
    chk_all("R10");

    for (int i = 0; i < LIMIT; i++) begin
      strobe(1'b0, 1'b1, 1'b0, 0, '0, "R6");
      chk_all("R6");
    end
    // Underflow with saved frames: refill and retry, twice.
    for (int i = 0; i < 2; i++) begin
      strobe(1'b0, 1'b1, 1'b0, 0, '0, "R8");
      chk_all("R8");
      strobe(1'b0, 1'b1, 1'b0, 0, '0, "R6");
      chk_all("R6");
    end
    // Nothing saved: underflow repeats with no movement.
    strobe(1'b0, 1'b1, 1'b0, 0, '0, "R8");
    strobe(1'b0, 1'b1, 1'b0, 0, '0, "R8");
    chk_all("R8");

    // Writes in the strobe cycle use the pre-strobe window.
    strobe(1'b1, 1'b0, 1'b1, 20, next_data(), "R11");
    chk_all("R11");
    strobe(1'b0, 1'b1, 1'b1, 12, next_data(), "R11");
    chk_all("R11");
    strobe(1'b1, 1'b0, 1'b1, 11, next_data(), "R11");
    chk_one("R11", 27);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule